// File: doc/BRIEF.md
# Chained Indirect Effective-Address Resolver

This unit turns a starting address into a final effective address by walking a chain of pointer words held in memory. Each pointer word carries an address field, an index-register selector and an indirection flag. While the flag is set the unit keeps fetching. At every level it adds the selected index register to the word's address field. When it meets a word with the flag clear, it reports the sum as the effective address. A level limit stops chains that refer back to themselves, and the unit reports an error pulse in that case.

Two small windows of low memory are auto-stepping pointers. When such a location is fetched as part of a chain, the unit uses its old value and then writes it back with the address field incremented (first window) or decremented (second window). This write happens one cycle after the word is evaluated and before the next level is fetched. Memory is reached through a plain synchronous port with a read latency of one cycle. The index registers come in as a flat vector from the surrounding datapath.

Top module: `ind_resolver`

## Requirements
- R1: After reset the unit is idle: `busy`, `done`, `err`, `mem_rd_en` and `mem_wr_en` are all low until a start is taken.
- R2: A start with `start_ind` low takes no memory cycle. `done` rises in the cycle after the start is sampled, and `ea` equals `start_addr`.
- R3: Pointer word format, with default widths: bit 35 is the indirection flag, bits 20:18 are the index selector and bits 17:0 are the address field. With `start_ind` high the first read is at `start_addr`. While a fetched word has its flag set, the next read is at (address field + selected index). The final `ea` is that same sum, taken from the first word whose flag is clear.
- R4: Selector 0 adds nothing. Selector k (1..7) adds index register k, which is `idx_regs[(k-1)*18 +: 18]`, with the sum wrapping modulo 2^18.
- R5: Each memory level takes three cycles: a read request with `mem_rd_en` high, the data cycle, and an evaluation cycle. Each writeback adds one cycle. `done` or `err` is therefore high 3N+W+1 clock edges after the sampling edge, where N is the number of reads and W the number of writebacks.
- R6: A word fetched from an address in 8..15 is used as read. It is then written back to the same address with its address field plus one, all other bits unchanged, in the cycle after evaluation.
- R7: A word fetched from an address in 16..23 is treated the same way, except that its address field is decremented, wrapping from 0 to 2^18-1.
- R8: If the 16th word read in one resolution still has its flag set, the unit pulses `err`, does not pulse `done`, and reads no further. A chain whose 16th word has the flag clear completes normally.
- R9: `done` and `err` are single-cycle pulses and never high together. A start raised while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a resolution (taken only when idle) |
| start_ind | input | 1 | Starting address is a pointer (1) or already final (0) |
| start_addr | input | AW | Starting address |
| idx_regs | input | (NIDX-1)*AW | Index registers 1..NIDX-1, packed from bit 0 upward |
| mem_rd_en | output | 1 | Memory read request |
| mem_wr_en | output | 1 | Memory write request (auto-step writeback) |
| mem_addr | output | AW | Memory address for read or write |
| mem_wdata | output | WW | Write data |
| mem_rdata | input | WW | Read data, valid one cycle after the request |
| busy | output | 1 | Resolution in progress |
| done | output | 1 | Pulse: `ea` holds the resolved address |
| err | output | 1 | Pulse: level limit exceeded |
| ea | output | AW | Resolved effective address |

## Verification
The bench holds its own memory image and runs a reference walker over it. Random memory fills, biased toward low addresses, produce chains of mixed depth that mix index selectors and repeatedly cross the auto-step windows. These separate errors in chain following, in index selection and in the writeback value. Directed cases cover the following, each of which isolates one rule:
- a start without indirection;
- a self-referencing word, which must hit the level limit;
- a chain of exactly the limit, which must not hit it;
- a decrement that wraps through zero;
- a start raised mid-resolution.

Comparing the cycle count and the whole memory image after each run also catches a missing or misplaced writeback.

// File: rtl/ind_res_pkg.sv
package ind_res_pkg;
   typedef enum logic [2:0] {
      S_IDLE  = 3'd0,
      S_READ  = 3'd1,
      S_WAIT  = 3'd2,
      S_EVAL  = 3'd3,
      S_WB    = 3'd4,
      S_DONE  = 3'd5,
      S_ERR   = 3'd6
   } res_state_t;
endpackage

// File: rtl/ind_idx_add.sv
module ind_idx_add #(
   parameter int AW   = 18,
   parameter int NIDX = 8,
   localparam int SW  = $clog2(NIDX)
) (
   input  logic [SW-1:0]          sel,
   input  logic [(NIDX-1)*AW-1:0] regs,
   input  logic [AW-1:0]          base,
   output logic [AW-1:0]          sum
);
   logic [AW-1:0] offs [NIDX];

   generate
      for (genvar k = 0; k < NIDX; k++) begin : g_off
         if (k == 0) begin : g_none
            assign offs[k] = '0;
         end else begin : g_reg
            assign offs[k] = regs[(k-1)*AW +: AW];
         end
      end
   endgenerate

   assign sum = base + offs[sel];
endmodule

// File: rtl/ind_auto_step.sv
module ind_auto_step #(
   parameter int AW        = 18,
   parameter int WW        = 36,
   parameter int AUTO_BASE = 8,
   parameter int AUTO_SPAN = 8
) (
   input  logic [AW-1:0] addr,
   input  logic [WW-1:0] word,
   output logic          special,
   output logic [WW-1:0] new_word
);
   generate
      if (AUTO_SPAN == 0) begin : g_off
         assign special  = 1'b0;
         assign new_word = word;
      end else begin : g_on
         localparam logic [AW-1:0] INC_LO = AW'(AUTO_BASE);
         localparam logic [AW-1:0] INC_HI = AW'(AUTO_BASE + AUTO_SPAN);
         localparam logic [AW-1:0] DEC_HI = AW'(AUTO_BASE + 2*AUTO_SPAN);
         logic is_inc, is_dec;
         assign is_inc  = (addr >= INC_LO) && (addr < INC_HI);
         assign is_dec  = (addr >= INC_HI) && (addr < DEC_HI);
         assign special = is_inc || is_dec;
         always_comb begin
            new_word = word;
            if (is_inc)      new_word[AW-1:0] = word[AW-1:0] + AW'(1);
            else if (is_dec) new_word[AW-1:0] = word[AW-1:0] - AW'(1);
         end
      end
   endgenerate
endmodule

// File: rtl/ind_level_guard.sv
module ind_level_guard #(
   parameter int MAX_LEVELS = 16,
   localparam int LW = $clog2(MAX_LEVELS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic at_limit
);
   logic [LW-1:0] count_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) count_q <= '0;
      else if (inc)      count_q <= count_q + LW'(1);
   end

   assign at_limit = (count_q == LW'(MAX_LEVELS));

   // R8: the read count never passes the limit
   p_lvl_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= LW'(MAX_LEVELS));
endmodule

// File: rtl/ind_resolver.sv
module ind_resolver
   import ind_res_pkg::*;
#(
   parameter int AW         = 18,
   parameter int WW         = 36,
   parameter int NIDX       = 8,
   parameter int MAX_LEVELS = 16,
   parameter int AUTO_BASE  = 8,
   parameter int AUTO_SPAN  = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic                   start_ind,
   input  logic [AW-1:0]          start_addr,
   input  logic [(NIDX-1)*AW-1:0] idx_regs,
   output logic                   mem_rd_en,
   output logic                   mem_wr_en,
   output logic [AW-1:0]          mem_addr,
   output logic [WW-1:0]          mem_wdata,
   input  logic [WW-1:0]          mem_rdata,
   output logic                   busy,
   output logic                   done,
   output logic                   err,
   output logic [AW-1:0]          ea
);
   localparam int SW   = $clog2(NIDX);
   localparam int FLAG = WW - 1;

   generate
      if (AW + SW >= WW) begin : g_bad_word
         $error("word too narrow for address, selector and flag");
      end
      if ((1 << SW) != NIDX) begin : g_bad_nidx
         $error("NIDX must be a power of two");
      end
      if (MAX_LEVELS < 1) begin : g_bad_lvl
         $error("MAX_LEVELS must be at least 1");
      end
      if (AUTO_BASE + 2*AUTO_SPAN > (1 << AW)) begin : g_bad_auto
         $error("auto-step windows exceed address space");
      end
   endgenerate

   res_state_t    state_q;
   logic [AW-1:0] cur_q, ea_q;
   logic [WW-1:0] word_q;
   logic [AW-1:0] sum;
   logic          special, at_limit, lvl_clr;
   logic [WW-1:0] stepped;

   ind_idx_add #(.AW(AW), .NIDX(NIDX)) u_add (
      .sel  (word_q[AW +: SW]),
      .regs (idx_regs),
      .base (word_q[AW-1:0]),
      .sum  (sum)
   );

   ind_auto_step #(.AW(AW), .WW(WW), .AUTO_BASE(AUTO_BASE),
                   .AUTO_SPAN(AUTO_SPAN)) u_step (
      .addr     (cur_q),
      .word     (word_q),
      .special  (special),
      .new_word (stepped)
   );

   assign lvl_clr = (state_q == S_IDLE) && start;

   ind_level_guard #(.MAX_LEVELS(MAX_LEVELS)) u_guard (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (lvl_clr),
      .inc      (state_q == S_READ),
      .at_limit (at_limit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         cur_q   <= '0;
         word_q  <= '0;
         ea_q    <= '0;
      end else begin
         unique case (state_q)
            S_IDLE: if (start) begin
               if (start_ind) begin
                  cur_q   <= start_addr;
                  state_q <= S_READ;
               end else begin
                  ea_q    <= start_addr;
                  state_q <= S_DONE;
               end
            end
            S_READ: state_q <= S_WAIT;
            S_WAIT: begin
               word_q  <= mem_rdata;
               state_q <= S_EVAL;
            end
            S_EVAL, S_WB: begin
               if (state_q == S_EVAL && special) begin
                  state_q <= S_WB;
               end else if (!word_q[FLAG]) begin
                  ea_q    <= sum;
                  state_q <= S_DONE;
               end else if (at_limit) begin
                  state_q <= S_ERR;
               end else begin
                  cur_q   <= sum;
                  state_q <= S_READ;
               end
            end
            S_DONE, S_ERR: state_q <= S_IDLE;
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign mem_rd_en = (state_q == S_READ);
   assign mem_wr_en = (state_q == S_WB);
   assign mem_addr  = cur_q;
   assign mem_wdata = stepped;
   assign busy      = (state_q != S_IDLE);
   assign done      = (state_q == S_DONE);
   assign err       = (state_q == S_ERR);
   assign ea        = ea_q;

   // R1: no memory traffic while idle
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_rd_en && !mem_wr_en));
   // R2: a direct start finishes next cycle with the start address
   p_direct_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && !start_ind) |=> (done && ea == $past(start_addr)));
   // R5: read and write never share a cycle
   p_port_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_en && mem_wr_en));
   // R6: writeback targets the location read three cycles before
   p_wb_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> ($past(mem_rd_en, 3) && mem_addr == $past(mem_addr, 3)));
   // R6: writeback keeps flag and selector bits of the fetched word
   p_wb_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> (mem_wdata[WW-1:AW] == $past(mem_rdata[WW-1:AW], 2)));
   // R9: completion pulses are exclusive and last one cycle
   p_pulse_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && err));
   p_pulse_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done || err) |=> !(done || err));
endmodule

// File: tb/ind_resolver_tb.sv
`timescale 1ns/1ps
module ind_resolver_tb;
   localparam int AW = 18;
   localparam int WW = 36;
   localparam int NIDX = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, start_ind = 1'b0;
   logic [AW-1:0] start_addr = '0;
   logic [(NIDX-1)*AW-1:0] idx_regs = '0;
   logic mem_rd_en, mem_wr_en, busy, done, err;
   logic [AW-1:0] mem_addr, ea;
   logic [WW-1:0] mem_wdata;
   logic [WW-1:0] mem_rdata = '0;

   logic [WW-1:0] mem [256];
   logic [WW-1:0] exp_mem [256];

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   ind_resolver u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .start_ind(start_ind),
      .start_addr(start_addr), .idx_regs(idx_regs),
      .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .busy(busy), .done(done), .err(err), .ea(ea)
   );

   always @(posedge clk) begin
      if (mem_rd_en) mem_rdata <= mem[mem_addr[7:0]];
      if (mem_wr_en) mem[mem_addr[7:0]] <= mem_wdata;
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   function automatic logic [WW-1:0] mk(input bit f, input int sel, input int a);
      logic [WW-1:0] w;
      w = '0;
      w[35] = f;
      w[20:18] = 3'(sel);
      w[17:0] = 18'(a);
      return w;
   endfunction

   task automatic put(input int a, input logic [WW-1:0] w);
      mem[a] = w;
      exp_mem[a] = w;
   endtask

   function automatic logic [AW-1:0] idx_val(input logic [2:0] s);
      if (s == 0) return '0;
      return idx_regs[(int'(s)-1)*AW +: AW];
   endfunction

   task automatic model(input logic [AW-1:0] a, input bit ind,
                        output logic [AW-1:0] e, output bit er, output int n, output int w);
      logic [AW-1:0] cur, s;
      logic [WW-1:0] wd;
      cur = a; n = 0; w = 0; er = 0; e = a;
      if (ind) begin
         forever begin
            wd = exp_mem[cur[7:0]];
            n++;
            s = wd[17:0] + idx_val(wd[20:18]);
            if (cur >= 8 && cur < 16) begin
               exp_mem[cur[7:0]] = {wd[35:18], wd[17:0] + 18'd1}; w++;
            end else if (cur >= 16 && cur < 24) begin
               exp_mem[cur[7:0]] = {wd[35:18], wd[17:0] - 18'd1}; w++;
            end
            if (!wd[35]) begin e = s; break; end
            if (n == 16) begin er = 1; break; end
            cur = s;
         end
      end
   endtask

   task automatic run_case(input logic [AW-1:0] a, input bit ind, input bit poke, input string tag);
      logic [AW-1:0] e;
      bit er;
      int n, w, lat, bad;
      model(a, ind, e, er, n, w);
      @(negedge clk);
      start = 1; start_addr = a; start_ind = ind;
      @(posedge clk); lat = 1;
      @(negedge clk); start = 0;
      while (!(done || err) && lat < 400) begin
         @(posedge clk); lat++;
         @(negedge clk);
         start = (poke && lat == 2);
         if (start) begin start_addr = a + 18'd3; start_ind = 0; end
      end
      start = 0;
      if (lat >= 400) chk(0, {tag, " watchdog"}, lat, 0);
      chk(err == er, {tag, " err flag R8"}, err, er);
      chk(done == !er, {tag, " done flag R9"}, done, !er);
      if (!er) chk(ea == e, {tag, " ea R3 R4"}, ea, e);
      chk(lat == 3*n + w + 1, {tag, " latency R5"}, lat, 3*n + w + 1);
      @(negedge clk);
      chk(!done && !err && !busy, {tag, " single pulse R9"}, {done, err, busy}, 0);
      bad = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) bad++;
      chk(bad == 0, {tag, " memory image R6 R7"}, bad, 0);
   endtask

   initial begin
      process::self().srandom(32'd1234);
      for (int i = 0; i < 256; i++) put(i, '0);
      for (int k = 0; k < NIDX-1; k++) idx_regs[k*AW +: AW] = 18'(k*5 + 2);
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1: reset state
      chk(!busy && !done && !err && !mem_rd_en && !mem_wr_en, "R1 idle after reset",
          {busy, done, err, mem_rd_en, mem_wr_en}, 0);

      // R2: direct start
      run_case(18'h2A5C1, 0, 0, "R2 direct");
      // R3 R4: single level, selector 0
      put(40, mk(0, 0, 77));
      run_case(40, 1, 0, "R3 one level");
      // R4: selector 3 adds register 3 (value 12)
      put(41, mk(1, 3, 50)); put(62, mk(0, 5, 100));
      run_case(41, 1, 0, "R4 indexed chain");
      // R4: wrap modulo 2^18
      put(42, mk(0, 7, 18'h3FFFF));
      run_case(42, 1, 0, "R4 wrap");
      // R8: self reference hits the limit
      put(45, mk(1, 0, 45));
      run_case(45, 1, 0, "R8 self loop");
      // R8: exactly 16 levels completes
      for (int k = 0; k < 15; k++) put(100 + k, mk(1, 0, 101 + k));
      put(115, mk(0, 0, 7));
      run_case(100, 1, 0, "R8 sixteen levels");
      // R8: seventeen needed -> error
      put(115, mk(1, 0, 116)); put(116, mk(0, 0, 7));
      run_case(100, 1, 0, "R8 seventeen levels");
      // R6: increment window
      put(9, mk(0, 0, 100));
      run_case(9, 1, 0, "R6 increment");
      // R7: decrement wraps through zero
      put(20, mk(0, 0, 0));
      run_case(20, 1, 0, "R7 decrement wrap");
      // R6 R7: chain through both windows
      put(50, mk(1, 0, 12)); put(12, mk(1, 0, 17)); put(17, mk(0, 1, 30));
      run_case(50, 1, 0, "R6 R7 mixed chain");
      // R9: start while busy ignored
      put(60, mk(1, 0, 61)); put(61, mk(0, 0, 300));
      run_case(60, 1, 1, "R9 busy start");

      // random chains
      for (int r = 0; r < 200; r++) begin
         if (r % 20 == 0) begin
            for (int i = 0; i < 256; i++)
               put(i, mk(($urandom % 3) != 0, $urandom % 8, $urandom % 64));
            for (int k = 0; k < NIDX-1; k++) idx_regs[k*AW +: AW] = 18'($urandom % 16);
         end
         run_case(18'($urandom % 64), ($urandom % 8) != 0, 0, "R3 random");
      end

      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule